// File: doc/BRIEF.md
# Precision Time Counter with Alarm, Trigger Capture and Pulse Outputs

This block keeps a 64-bit time value that runs on the timer reference clock. On every clock it adds a programmable increment. A greater-or-equal comparator drives a latched alarm output. Two asynchronous trigger inputs each record the time at which they rise. Three periodic pulse outputs and one divided clock output are all registered in the timer clock domain, so their edges line up with that clock.

Software reaches the block through a plain port: a write strobe, an address, write data, and read data that is decoded combinationally. The alarm value is loaded in two steps. The low word is held first, and the write of the high word loads the full value. Each trigger has its own event flag, which stays set until software writes a 1 to its bit.

Top module: `prec_timer`

## Requirements
- R1: After reset the time reads 0 and the increment (address 0) reads 1. Every later clock adds the current increment to the time. The time reads low word at address 7 and high word at address 8.
- R2: Once armed, the alarm output is high in the cycle after any clock at which the time was greater than or equal to the 64-bit alarm value.
- R3: Once high, the alarm stays high. A write of the low alarm word (address 1) does not clear it.
- R4: A write of the high alarm word (address 2) loads {high word, held low word}, clears the alarm and arms the comparator. From reset until the first such write, the alarm stays low.
- R5: A rise on trigger input i passes through a two-stage synchroniser. It then captures the time at the third clock edge after the rise. The captured value is the time shown two cycles before that edge plus twice the increment. The capture reads low/high at addresses 9+2i and 10+2i.
- R6: Event flag i is bit i at address 13. It is set by a capture and stays set. Writing 1 to bit i clears it.
- R7: Pulse output k has its period at address 3+k. It is high for exactly one clock every period clocks. After the period is written, the first pulse is visible period cycles after the write edge.
- R8: A period of 0 keeps that pulse output low.
- R9: The divider ratio N is at address 6. For N of 2 or more, the clock output has a period of N cycles and is high for floor(N/2) of them.
- R10: A divider ratio below 2 holds the clock output low.
- R11: While reset is held, all outputs are low and the event flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| trig_in | input | 2 | Asynchronous trigger inputs |
| pulse_out | output | 3 | Periodic one-clock pulses |
| clk_out | output | 1 | Divided clock |
| alarm_out | output | 1 | Latched alarm |

## Verification
The bench sets alarm values both ahead of the time and behind it. A comparator that tested only equality would never fire for a target already passed. A value loaded on the low-word write, rather than at commit, would show up as a wrong alarm cycle. After the alarm has fired, the bench rewrites the low word to catch a design that clears the alarm too early. Trigger captures are compared against the exact expected time, so a synchroniser stage too many or too few gives a capture off by one increment. Pulse spacing, period 0 and 1, and odd divider ratios and ratios below 2 expose off-by-one errors in the counters.

// File: rtl/prec_timer.sv
module prec_timer #(
  parameter int DW = 32,
  parameter int NP = 3,
  parameter int NT = 2,
  parameter int NW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NT-1:0] trig_in,
  output logic [NP-1:0] pulse_out,
  output logic          clk_out,
  output logic          alarm_out
);
  localparam int TW     = 2 * DW;
  localparam int A_INC  = 0;
  localparam int A_ALO  = 1;
  localparam int A_AHI  = 2;
  localparam int A_PER0 = 3;
  localparam int A_DIV  = A_PER0 + NP;
  localparam int A_TLO  = A_DIV + 1;
  localparam int A_THI  = A_DIV + 2;
  localparam int A_CAP0 = A_DIV + 3;
  localparam int A_EVT  = A_CAP0 + 2 * NT;

  logic [TW-1:0] tm, alarm_val;
  logic [DW-1:0] inc, alo_stage;
  logic          armed;
  logic [DW-1:0] per [NP];
  logic [DW-1:0] pcnt [NP];
  logic [TW-1:0] cap [NT];
  logic [2:0]    tsync [NT];
  logic [NT-1:0] evt;
  logic [NW-1:0] div_n, dcnt;

  wire wr_ahi = wr_en && int'(addr) == A_AHI;
  wire wr_div = wr_en && int'(addr) == A_DIV;
  wire wr_evt = wr_en && int'(addr) == A_EVT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tm        <= '0;
      inc       <= DW'(1);
      alo_stage <= '0;
      alarm_val <= '0;
      armed     <= 1'b0;
      alarm_out <= 1'b0;
    end else begin
      tm <= tm + TW'(inc);
      if (wr_en && int'(addr) == A_INC) inc <= wdata;
      if (wr_en && int'(addr) == A_ALO) alo_stage <= wdata;
      if (wr_ahi) begin
        alarm_val <= {wdata, alo_stage};
        armed     <= 1'b1;
        alarm_out <= 1'b0;
      end else if (armed && tm >= alarm_val) begin
        alarm_out <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        tsync[i] <= '0;
        cap[i]   <= '0;
      end
      evt <= '0;
    end else begin
      for (int i = 0; i < NT; i++) begin
        tsync[i] <= {tsync[i][1:0], trig_in[i]};
        if (wr_evt && wdata[i]) evt[i] <= 1'b0;
        if (tsync[i][1] && !tsync[i][2]) begin
          cap[i] <= tm;
          evt[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NP; k++) begin
        per[k]  <= '0;
        pcnt[k] <= '0;
      end
      pulse_out <= '0;
    end else begin
      for (int k = 0; k < NP; k++) begin
        if (wr_en && int'(addr) == A_PER0 + k) begin
          per[k]       <= wdata;
          pcnt[k]      <= '0;
          pulse_out[k] <= 1'b0;
        end else if (per[k] == '0) begin
          pcnt[k]      <= '0;
          pulse_out[k] <= 1'b0;
        end else if (pcnt[k] >= per[k] - 1'b1) begin
          pcnt[k]      <= '0;
          pulse_out[k] <= 1'b1;
        end else begin
          pcnt[k]      <= pcnt[k] + 1'b1;
          pulse_out[k] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_n   <= '0;
      dcnt    <= '0;
      clk_out <= 1'b0;
    end else if (wr_div) begin
      div_n   <= wdata[NW-1:0];
      dcnt    <= '0;
      clk_out <= 1'b0;
    end else if (div_n < NW'(2)) begin
      dcnt    <= '0;
      clk_out <= 1'b0;
    end else begin
      dcnt    <= (dcnt >= div_n - 1'b1) ? '0 : dcnt + 1'b1;
      clk_out <= dcnt < (div_n >> 1);
    end
  end

  always_comb begin
    rdata = '0;
    case (int'(addr))
      A_INC:   rdata = inc;
      A_ALO:   rdata = alo_stage;
      A_AHI:   rdata = alarm_val[TW-1:DW];
      A_DIV:   rdata = DW'(div_n);
      A_TLO:   rdata = tm[DW-1:0];
      A_THI:   rdata = tm[TW-1:DW];
      A_EVT:   rdata = DW'(evt);
      default: rdata = '0;
    endcase
    for (int k = 0; k < NP; k++)
      if (int'(addr) == A_PER0 + k) rdata = per[k];
    for (int i = 0; i < NT; i++) begin
      if (int'(addr) == A_CAP0 + 2 * i)     rdata = cap[i][DW-1:0];
      if (int'(addr) == A_CAP0 + 2 * i + 1) rdata = cap[i][TW-1:DW];
    end
  end

  a_r1_time_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tm == $past(tm) + TW'($past(inc)));
  a_r3_alarm_held: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_out && !wr_ahi) |=> alarm_out);
  a_r4_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ahi |=> !alarm_out);
  a_r10_div_low: assert property (@(posedge clk) disable iff (!rst_n)
    (div_n < NW'(2) && !wr_div) |=> !clk_out);

  for (genvar g = 0; g < NP; g++) begin : g_pchk
    a_r7_pulse_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_out[g] && per[g] > DW'(1) && !wr_en) |=> !pulse_out[g]);
  end
  for (genvar g = 0; g < NT; g++) begin : g_tchk
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[g] && !(wr_evt && wdata[g])) |=> evt[g]);
  end
endmodule

// File: tb/sim_prec_timer.sv
module sim_prec_timer;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0] trig_in = 0;
  logic [2:0] pulse_out;
  logic clk_out, alarm_out;
  int total = 0, bad = 0;

  prec_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .trig_in(trig_in), .pulse_out(pulse_out), .clk_out(clk_out),
    .alarm_out(alarm_out));

  always #5 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic rd(int a, output logic [31:0] d); addr = 4'(a); #1; d = rdata; endtask
  task automatic rd64(int a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 1, hi); v = {hi, lo};
  endtask
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic alarm_exp(logic [63:0] t, logic [31:0] inc, logic [63:0] a);
    return (t - 64'(inc)) >= a;
  endfunction

  task automatic alarm_run(logic [31:0] inc, int offset, int n);
    logic [63:0] t, a;
    wr(0, inc); tick();
    rd64(7, t);
    a = t + 64'(signed'(64'(offset)));
    wr(1, a[31:0]); wr(2, a[63:32]);
    check("R4 commit clears", 64'(alarm_out), 0);
    for (int i = 0; i < n; i++) begin
      tick(); rd64(7, t);
      check("R2 alarm compare", 64'(alarm_out), 64'(alarm_exp(t, inc, a)));
    end
    wr(1, $urandom);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3 alarm held", 64'(alarm_out), 1);
    end
  endtask

  task automatic trig_run(int idx);
    logic [63:0] t0, c, c2;
    logic [31:0] inc, ev;
    tick(); rd(0, inc); rd64(7, t0);
    trig_in[idx] = 1;
    repeat (4) tick();
    rd64(9 + 2 * idx, c);
    check("R5 capture value", c, t0 + 2 * 64'(inc));
    rd(13, ev); check("R6 flag set", 64'(ev[idx]), 1);
    repeat (3) tick();
    rd64(9 + 2 * idx, c2); check("R5 no recapture", c2, c);
    rd(13, ev); check("R6 flag sticky", 64'(ev[idx]), 1);
    trig_in[idx] = 0;
    wr(13, 32'(1) << idx);
    rd(13, ev); check("R6 flag clear", 64'(ev[idx]), 0);
  endtask

  task automatic pulse_run(int p0, int p1, int p2);
    int p[3], last[3], cnt[3], first2;
    p[0] = p0; p[1] = p1; p[2] = p2;
    wr(3, p0); wr(4, p1); wr(5, p2);
    first2 = -1;
    for (int k = 0; k < 3; k++) begin last[k] = -1; cnt[k] = 0; end
    for (int i = 1; i <= 60; i++) begin
      tick();
      for (int k = 0; k < 3; k++) if (pulse_out[k]) begin
        if (k == 2 && first2 < 0) first2 = i;
        if (last[k] >= 0) check("R7 pulse spacing", 64'(i - last[k]), 64'(p[k]));
        last[k] = i; cnt[k]++;
      end
    end
    for (int k = 0; k < 3; k++) begin
      if (p[k] == 0) check("R8 disabled pulse count", 64'(cnt[k]), 0);
      else check("R7 pulse count", 64'(cnt[k] >= 60 / p[k] - 2), 1);
    end
    if (p2 > 0) check("R7 first pulse", 64'(first2), 64'(p2));
  endtask

  task automatic div_run(int n);
    int highs, lastr;
    logic prev;
    wr(6, n);
    repeat (2 * n + 4) tick();
    highs = 0; lastr = -1; prev = clk_out;
    if (n < 2) begin
      for (int i = 0; i < 20; i++) begin tick(); highs += clk_out; end
      check("R10 divider low", 64'(highs), 0);
    end else begin
      for (int i = 0; i < 2 * n; i++) begin
        tick(); highs += clk_out;
        if (clk_out && !prev) begin
          if (lastr >= 0) check("R9 divider period", 64'(i - lastr), 64'(n));
          lastr = i;
        end
        prev = clk_out;
      end
      check("R9 divider high time", 64'(highs), 64'(2 * (n / 2)));
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] t1, t2;
    void'($urandom(1234));
    repeat (3) tick();
    rd64(7, t1); check("R11 reset time", t1, 0);
    rd(0, d); check("R11 reset increment", 64'(d), 1);
    rd(13, d); check("R11 reset flags", 64'(d), 0);
    check("R11 reset outputs", 64'({pulse_out, clk_out, alarm_out}), 0);
    rst_n = 1;
    for (int i = 0; i < 10; i++) begin
      tick(); check("R4 unarmed alarm low", 64'(alarm_out), 0);
    end
    rd64(7, t1); tick(); rd64(7, t2);
    check("R1 time step", t2 - t1, 1);
    wr(0, 32'h0001_0000); tick();
    rd64(7, t1); tick(); rd64(7, t2);
    check("R1 time step custom", t2 - t1, 64'h1_0000);

    alarm_run(32'd3, 30, 20);
    alarm_run(32'd1, -5, 5);
    alarm_run(32'h8000_0001, 8, 12);
    trig_run(0);
    trig_run(1);
    pulse_run(1, 0, 7);
    pulse_run(0, 2, 9);
    div_run(0); div_run(1); div_run(2); div_run(3); div_run(8);

    for (int r = 0; r < 6; r++) begin
      int o;
      o = int'($urandom_range(0, 14));
      alarm_run($urandom_range(1, 1 << 20), o, 16);
      trig_run(r % 2);
      pulse_run($urandom_range(0, 9), $urandom_range(0, 9), $urandom_range(0, 9));
      div_run($urandom_range(0, 12));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule